// File: doc/BRIEF.md
# Ternary Model-Predictive Pulse Selector

This block drives the switch of a switching digital-to-analogue converter with a ternary pulse stream. Every clock it takes one oversampled target sample and holds a two-element fixed-point state that models a second-order output filter. For each of the three pulse values (+1, 0, −1) it predicts the filter's next output. It then issues the pulse whose predicted output lies closest to the target, and advances the model state with that pulse.

The model constants are the state transition matrix, the pulse response vector, the output row applied to the transition matrix, and the output response to one pulse. They live in a small write-only register bank, together with an initial state, and can be rewritten at any time. A synchronous `load` input restarts the model from the stored initial state.

The critical loop is one register deep. Three speculative branches work in parallel, one for each value the previous pulse could have taken. Each branch forms its candidate state, its prediction, its next partial state and its own pulse choice. The registered previous pulse then picks which branch's results are kept.

Top module: `mps_pulse_sel`

## Requirements
- R1: `pulse_o[0]` is 1 when the pulse is nonzero and `pulse_o[1]` is 1 when the pulse is −1, so +1 is 2'b01, 0 is 2'b00 and −1 is 2'b11. The code 2'b10 never appears.
- R2: The target sampled at a rising edge gives the pulse shown on `pulse_o` right after that edge. That pulse minimises |target − (cphi0·x0 + cphi1·x1 + u·cp)| over u in {+1, 0, −1}, where (x0, x1) is the model state for that step.
- R3: When absolute errors are equal, 0 is preferred, then +1, then −1.
- R4: After a step with pulse u, the model state becomes the transition matrix times the state, plus u times the pulse vector: x0' = phi00·x0 + phi01·x1 + u·p0 and x1' = phi10·x0 + phi11·x1 + u·p1.
- R5: All values are signed two's complement, 20 bits wide with 16 fraction bits.
  - Each product is shifted right by 16 with rounding toward minus infinity.
  - Each sum of two products saturates to 20 bits. This covers each row of the transition product and the prediction.
  - Each state element plus or minus its pulse term also saturates to 20 bits.
  - The error comparison uses full precision.
- R6: A rising edge with `load` high does three things: it sets the state to (init0, init1), clears the pulse register to 0, and makes `valid_o` low. The next step then starts from that initial state with a previous pulse of 0.
- R7: `valid_o` is low after reset and after a load edge. It is high after every edge at which `load` was low.
- R8: A rising edge with `cfg_we_i` high writes `cfg_wdata_i` to the constant selected by `cfg_addr_i`. The address map is 0 phi00, 1 phi01, 2 phi10, 3 phi11, 4 p0, 5 p1, 6 cphi0, 7 cphi1, 8 cp, 9 init0, 10 init1. The step evaluated in the same cycle as the write still uses the old value; the step in the next cycle uses the new value. A write does not disturb the running state.
- R9: Asynchronous reset clears every constant, the state and the pulse register to zero and makes `valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Synchronous restart from the stored initial state |
| target_i | input | 20 | Signed target sample, 16 fraction bits |
| cfg_we_i | input | 1 | Constant bank write strobe |
| cfg_addr_i | input | 4 | Constant bank address |
| cfg_wdata_i | input | 20 | Constant bank write data |
| pulse_o | output | 2 | Pulse code: bit 1 is sign, bit 0 is enable |
| valid_o | output | 1 | Pulse carries a computed step |

## Verification
The bench sweeps the target across both exact midpoints between pulse levels, with zero prediction gain. A selector with the wrong tie order would emit ±1 there instead of 0. A transition matrix with gain 3 drives the state into the rails: a design that wraps instead of saturating flips its pulse pattern within a few steps. Constants are rewritten in the middle of a run, so a write that takes effect a cycle early or late makes the pulse stream diverge. A load issued mid-run must clear the previous pulse; a design that kept a stale pulse would pick the wrong speculative branch on the first step after restart.

// File: rtl/mps_pkg.sv
`timescale 1ns/1ps
package mps_pkg;
  localparam int unsigned MPS_W      = 20;
  localparam int unsigned MPS_F      = 16;
  localparam int unsigned MPS_AW     = 2*MPS_W + 2;
  localparam int unsigned MPS_NCOEF  = 11;
  localparam int unsigned MPS_ADDR_W = $clog2(MPS_NCOEF);

  typedef logic signed [MPS_W-1:0]  mps_val_t;
  typedef logic signed [MPS_AW-1:0] mps_acc_t;
  typedef logic signed [1:0]        mps_pulse_t;

  typedef struct packed {
    mps_val_t e1;
    mps_val_t e0;
  } mps_vec_t;

  typedef struct packed {
    mps_val_t phi00, phi01, phi10, phi11;
    mps_val_t p0, p1;
    mps_val_t cphi0, cphi1, cp;
    mps_val_t init0, init1;
  } mps_coef_t;

  typedef enum logic [MPS_ADDR_W-1:0] {
    A_PHI00 = 0, A_PHI01 = 1, A_PHI10 = 2, A_PHI11 = 3,
    A_P0    = 4, A_P1    = 5, A_CPHI0 = 6, A_CPHI1 = 7,
    A_CP    = 8, A_INIT0 = 9, A_INIT1 = 10
  } mps_addr_e;

  localparam mps_acc_t MPS_MAX = (mps_acc_t'(1) <<< (MPS_W-1)) - mps_acc_t'(1);
  localparam mps_acc_t MPS_MIN = -(mps_acc_t'(1) <<< (MPS_W-1));

  function automatic mps_acc_t mps_ext(mps_val_t v);
    return mps_acc_t'(v);
  endfunction

  // fixed-point product, floor-shifted back to the value scale
  function automatic mps_acc_t mps_mulq(mps_val_t a, mps_val_t b);
    mps_acc_t pr;
    pr = mps_ext(a) * mps_ext(b);
    return pr >>> MPS_F;
  endfunction

  function automatic mps_val_t mps_sat(mps_acc_t v);
    if (v > MPS_MAX) return MPS_MAX[MPS_W-1:0];
    if (v < MPS_MIN) return MPS_MIN[MPS_W-1:0];
    return v[MPS_W-1:0];
  endfunction

  function automatic mps_acc_t mps_abs(mps_acc_t v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/mps_coef_regs.sv
`timescale 1ns/1ps
module mps_coef_regs
  import mps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [MPS_ADDR_W-1:0] addr,
  input  mps_val_t              wdata,
  output mps_coef_t             coef
);
  logic [MPS_NCOEF-1:0][MPS_W-1:0] bank_q;

  for (genvar i = 0; i < MPS_NCOEF; i++) begin : g_slot
    logic hit;
    assign hit = we && (addr == MPS_ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q[i] <= '0;
      else if (hit) bank_q[i] <= wdata;
    end
  end

  always_comb begin
    coef.phi00 = bank_q[A_PHI00];
    coef.phi01 = bank_q[A_PHI01];
    coef.phi10 = bank_q[A_PHI10];
    coef.phi11 = bank_q[A_PHI11];
    coef.p0    = bank_q[A_P0];
    coef.p1    = bank_q[A_P1];
    coef.cphi0 = bank_q[A_CPHI0];
    coef.cphi1 = bank_q[A_CPHI1];
    coef.cp    = bank_q[A_CP];
    coef.init0 = bank_q[A_INIT0];
    coef.init1 = bank_q[A_INIT1];
  end

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(bank_q)); // R8
endmodule

// File: rtl/mps_argmin3.sv
`timescale 1ns/1ps
module mps_argmin3
  import mps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mps_acc_t   e_neg,
  input  mps_acc_t   e_zero,
  input  mps_acc_t   e_pos,
  output mps_pulse_t pick
);
  mps_acc_t chosen_err;

  // priority: zero, then plus, then minus
  always_comb begin
    pick = 2'sd0;
    if ((e_pos < e_zero) && (e_pos <= e_neg))      pick = 2'sd1;
    else if ((e_neg < e_zero) && (e_neg < e_pos))  pick = -2'sd1;
  end

  assign chosen_err = (pick == 2'sd1) ? e_pos : ((pick == -2'sd1) ? e_neg : e_zero);

  AST_MIN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (chosen_err <= e_zero) && (chosen_err <= e_pos) && (chosen_err <= e_neg)); // R2
  AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_zero <= e_pos) && (e_zero <= e_neg)) |-> (pick == 2'sd0)); // R3
endmodule

// File: rtl/mps_branch.sv
`timescale 1ns/1ps
module mps_branch
  import mps_pkg::*;
#(
  parameter int JOFF = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mps_vec_t   xp,
  input  mps_coef_t  coef,
  input  mps_val_t   target,
  output mps_pulse_t pick,
  output mps_vec_t   xp_next
);
  mps_acc_t p0_term, p1_term;
  mps_vec_t xj;
  mps_val_t pred;
  mps_acc_t diff, e_neg, e_zero, e_pos;

  // the assumed previous pulse selects the pulse-vector term
  if (JOFF > 0) begin : g_pos
    assign p0_term = mps_ext(coef.p0);
    assign p1_term = mps_ext(coef.p1);
  end else if (JOFF < 0) begin : g_neg
    assign p0_term = -mps_ext(coef.p0);
    assign p1_term = -mps_ext(coef.p1);
  end else begin : g_zero
    assign p0_term = '0;
    assign p1_term = '0;
  end

  always_comb begin
    xj.e0     = mps_sat(mps_ext(xp.e0) + p0_term);
    xj.e1     = mps_sat(mps_ext(xp.e1) + p1_term);
    pred      = mps_sat(mps_mulq(coef.cphi0, xj.e0) + mps_mulq(coef.cphi1, xj.e1));
    diff      = mps_ext(target) - mps_ext(pred);
    e_zero    = mps_abs(diff);
    e_pos     = mps_abs(diff - mps_ext(coef.cp));
    e_neg     = mps_abs(diff + mps_ext(coef.cp));
    xp_next.e0 = mps_sat(mps_mulq(coef.phi00, xj.e0) + mps_mulq(coef.phi01, xj.e1));
    xp_next.e1 = mps_sat(mps_mulq(coef.phi10, xj.e0) + mps_mulq(coef.phi11, xj.e1));
  end

  mps_argmin3 u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .e_neg  (e_neg),
    .e_zero (e_zero),
    .e_pos  (e_pos),
    .pick   (pick)
  );
endmodule

// File: rtl/mps_pulse_sel.sv
`timescale 1ns/1ps
module mps_pulse_sel
  import mps_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic signed [MPS_W-1:0]      target_i,
  input  logic                         cfg_we_i,
  input  logic [MPS_ADDR_W-1:0]        cfg_addr_i,
  input  logic signed [MPS_W-1:0]      cfg_wdata_i,
  output logic [1:0]                   pulse_o,
  output logic                         valid_o
);
  mps_coef_t  coef;
  mps_vec_t   xp_q, xp_d;
  mps_pulse_t u_q, u_d;
  logic       valid_q, valid_d;
  mps_pulse_t pick [3];
  mps_vec_t   xpn  [3];

  mps_coef_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we_i),
    .addr  (cfg_addr_i),
    .wdata (cfg_wdata_i),
    .coef  (coef)
  );

  // one speculative branch per possible previous pulse: index 0 -> -1, 1 -> 0, 2 -> +1
  for (genvar g = 0; g < 3; g++) begin : g_br
    mps_branch #(.JOFF(g - 1)) u_br (
      .clk     (clk),
      .rst_n   (rst_n),
      .xp      (xp_q),
      .coef    (coef),
      .target  (target_i),
      .pick    (pick[g]),
      .xp_next (xpn[g])
    );
  end

  always_comb begin
    case (u_q)
      2'sd1:   begin u_d = pick[2]; xp_d = xpn[2]; end
      -2'sd1:  begin u_d = pick[0]; xp_d = xpn[0]; end
      default: begin u_d = pick[1]; xp_d = xpn[1]; end
    endcase
    valid_d = 1'b1;
    if (load) begin
      xp_d.e0 = coef.init0;
      xp_d.e1 = coef.init1;
      u_d     = 2'sd0;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xp_q    <= '0;
      u_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      xp_q    <= xp_d;
      u_q     <= u_d;
      valid_q <= valid_d;
    end
  end

  assign pulse_o = {u_q[1], (u_q != 2'sd0)};
  assign valid_o = valid_q;

  AST_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o != 2'b10); // R1
  AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((pulse_o == 2'b00) && !valid_o)); // R6
  AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> valid_o); // R7
endmodule

// File: tb/tb_mps_pulse_sel.sv
`timescale 1ns/1ps
module tb_mps_pulse_sel;
  import mps_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic cfg_we = 1'b0;
  logic [MPS_ADDR_W-1:0] cfg_addr = '0;
  logic signed [MPS_W-1:0] target = '0;
  logic signed [MPS_W-1:0] cfg_wdata = '0;
  logic [1:0] pulse;
  logic valid;

  always #2.5 clk = ~clk;

  mps_pulse_sel dut (
    .clk(clk), .rst_n(rst_n), .load(load), .target_i(target),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pulse_o(pulse), .valid_o(valid)
  );

  localparam longint ONE  = longint'(1) <<< MPS_F;
  localparam longint VMAX = (longint'(1) <<< (MPS_W-1)) - 1;
  localparam longint VMIN = -(longint'(1) <<< (MPS_W-1));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint cf [MPS_NCOEF];
  longint mxp0, mxp1;
  int mu;

  function automatic longint bsat(longint v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction
  function automatic longint bmul(longint a, longint b);
    return (a * b) >>> MPS_F;
  endfunction
  function automatic longint babs(longint v);
    return (v < 0) ? -v : v;
  endfunction
  function automatic logic [1:0] enc(int u);
    return (u == 1) ? 2'b01 : ((u == -1) ? 2'b11 : 2'b00);
  endfunction

  // reference model of one step: returns the pulse, advances state
  function automatic int model_step(longint t);
    longint x0, x1, pb, d, e0, ep, en;
    int u;
    x0 = bsat(mxp0 + mu * cf[4]);
    x1 = bsat(mxp1 + mu * cf[5]);
    pb = bsat(bmul(cf[6], x0) + bmul(cf[7], x1));
    d  = t - pb;
    e0 = babs(d); ep = babs(d - cf[8]); en = babs(d + cf[8]);
    u = 0;
    if (ep < e0 && ep <= en) u = 1;
    else if (en < e0 && en < ep) u = -1;
    mxp0 = bsat(bmul(cf[0], x0) + bmul(cf[1], x1));
    mxp1 = bsat(bmul(cf[2], x0) + bmul(cf[3], x1));
    mu = u;
    return u;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {valid,pulse} got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input longint t, input string tag, input bit we = 1'b0,
                      input int addr = 0, input longint wd = 0);
    int u;
    target    = t[MPS_W-1:0];
    cfg_we    = we;
    cfg_addr  = addr[MPS_ADDR_W-1:0];
    cfg_wdata = wd[MPS_W-1:0];
    u = model_step(t);
    if (we && addr < MPS_NCOEF) cf[addr] = wd;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    check(tag, {valid, pulse}, {1'b1, enc(u)});
  endtask

  task automatic wr(input int addr, input longint wd);
    cfg_we = 1'b1; cfg_addr = addr[MPS_ADDR_W-1:0]; cfg_wdata = wd[MPS_W-1:0];
    cf[addr] = wd;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic do_load(input string tag);
    load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
    mxp0 = cf[9]; mxp1 = cf[10]; mu = 0;
    check(tag, {valid, pulse}, 3'b000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    foreach (cf[i]) cf[i] = 0;
    mxp0 = 0; mxp1 = 0; mu = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset state", {valid, pulse}, 3'b000);
    rst_n = 1'b1;
    // constants cleared: every error ties, pulse 0, valid rises
    step(12345, "R9 R7 R3 zeroed constants");
    step(-777, "R9 R7 R3 zeroed constants");
    step(0, "R9 R7 zeroed constants");

    // second-order model, triangle target, mid-run rewrites
    wr(0, 64225); wr(1, 1311); wr(2, -58982); wr(3, 62259);
    wr(4, 655); wr(5, 32768); wr(6, 64225); wr(7, 1311); wr(8, 655);
    wr(9, 6554); wr(10, 0);
    do_load("R6 load after config");
    for (int i = 0; i < 600; i++) begin
      longint ph, t;
      ph = i % 200;
      t = ((ph < 100) ? ph : (200 - ph)) * ONE / 200 - ONE / 4;
      if (i == 300)      step(t, "R8 cp rewrite", 1'b1, 8, 1310);
      else if (i == 350) step(t, "R8 p1 rewrite", 1'b1, 5, 16384);
      else if (i == 400) step(t, "R8 init1 rewrite", 1'b1, 10, -3277);
      else               step(t, "R2 R4 triangle");
    end
    do_load("R6 mid-run load");
    for (int i = 0; i < 50; i++) step(ONE / 20, "R6 restart from init");

    // first-order model, pseudo-random target
    wr(0, 62259); wr(1, 0); wr(2, 0); wr(3, 0);
    wr(4, 3277); wr(5, 0); wr(6, 62259); wr(7, 0); wr(8, 3277);
    wr(9, 0); wr(10, 0);
    do_load("R6 load first-order");
    lf = 16'hACE1;
    for (int i = 0; i < 500; i++) begin
      step(longint'(lf) - 32768, "R1 R2 R4 random");
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end

    // tie sweep: prediction gain zero, step of 1000 per pulse
    wr(6, 0); wr(7, 0); wr(8, 1000);
    do_load("R6 load tie sweep");
    for (int t = -1500; t <= 1500; t++) step(t, "R3 tie sweep");
    wr(8, 0);
    do_load("R6 load equal errors");
    for (int i = 0; i < 20; i++) step(i * 1000 - 9000, "R3 all equal");

    // saturation: gain 3 drives state to the rails
    wr(0, 3 * ONE); wr(1, 0); wr(2, 0); wr(3, 3 * ONE);
    wr(4, ONE); wr(5, ONE); wr(6, ONE); wr(7, ONE / 2); wr(8, ONE / 2);
    wr(9, 5 * ONE); wr(10, -5 * ONE);
    do_load("R6 load saturation");
    for (int i = 0; i < 100; i++) step(((i % 4) < 2) ? 7 * ONE : -7 * ONE, "R5 saturation");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule